// File: doc/BRIEF.md
# Interrupt Vector Message Table

This block is the storage and access logic for the per-vector message table of a message-signalled interrupt controller. It holds `NUM_VEC` entries. Each entry has a 64-bit message address (a low word and a high word), a 32-bit message data word and a 32-bit vector control word. Bit 0 of the control word masks the vector. A memory-mapped slave port reaches every entry with 4-byte or 8-byte reads and writes. The byte offset on that port splits into a vector index (offset divided by 16) and a field within the entry (offset modulo 16).

The block also holds the two writable bits of the message control register: a global enable and a function mask. A delivery engine outside the block reads each vector's mask state, address and data from flat output buses. Whenever a write clears a vector's mask bit, the block sends that engine a one-cycle unmask event carrying the vector index. The engine can then deliver a message that was held pending. Bus bridging and message delivery are done elsewhere.

Top module: `vec_table_regs`

## Requirements
- R1: After reset, every entry reads as zero in all fields except vector control, which reads 0x0000_0001. All bits of `vec_masked` are 1. `ctl_rdata` reads 0x4000 | (NUM_VEC-1), which is enable 0 and function mask 1.
- R2: A 4-byte access (`wide`=0) at entry offset 0x0, 0x4, 0x8 or 0xC reaches the address low word, the address high word, the message data or the vector control word, in that order. Write data is taken from `wdata[31:0]`. Read data appears in `rsp_data[31:0]`, and `rsp_data[63:32]` is zero.
- R3: An 8-byte access (`wide`=1) at entry offset 0x0 carries the address high word in bits 63:32 and the address low word in bits 31:0. At entry offset 0x8 it carries vector control in bits 63:32 and message data in bits 31:0.
- R4: An access whose vector index (`addr`/16) is NUM_VEC or above reads as all ones: 0x0000_0000_FFFF_FFFF for a 4-byte read and 0xFFFF_FFFF_FFFF_FFFF for an 8-byte read. The index is checked before the offset. Such a write changes no entry and causes no unmask event.
- R5: For an index in range, a 4-byte access at any entry offset other than 0x0, 0x4, 0x8 or 0xC, or an 8-byte access at an offset other than 0x0 or 0x8, reads as zero and its write changes nothing.
- R6: `vec_masked[i]` equals bit 0 of entry i's control word. `vec_addr[64*i +: 64]` is {address high, address low} of entry i. `vec_data[32*i +: 32]` is entry i's message data. All of these reflect a write from the cycle after it.
- R7: A control write stores `ctl_wdata[15]` as the global enable and `ctl_wdata[14]` as the function mask. `ctl_rdata[10:0]` always reads NUM_VEC-1 and `ctl_rdata[13:11]` reads zero. Without a control write, `ctl_rdata` holds its value.
- R8: A write that changes a vector's control bit 0 from 1 to 0 raises `unmask_valid` for exactly one cycle, in the cycle after the write, with `unmask_idx` set to that vector. Writes that leave bit 0 at 0, leave it at 1, or set it raise nothing.
- R9: Each read request gets exactly one cycle of `rsp_valid` with its data in the following cycle. Writes complete in their request cycle and produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Table access request, one per cycle |
| we | input | 1 | 1 = write, 0 = read |
| wide | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| addr | input | ADDR_W | Byte offset into the table |
| wdata | input | 64 | Write data, little-endian lanes |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 64 | Read data |
| ctl_we | input | 1 | Message control register write |
| ctl_wdata | input | 16 | Message control write data |
| ctl_rdata | output | 16 | Message control register value |
| glb_enable | output | 1 | Global enable bit |
| fn_mask | output | 1 | Function mask bit |
| vec_masked | output | NUM_VEC | Per-vector mask state |
| vec_addr | output | 64*NUM_VEC | Per-vector message address |
| vec_data | output | 32*NUM_VEC | Per-vector message data |
| unmask_valid | output | 1 | One-cycle unmask event |
| unmask_idx | output | IDX_W | Vector index of the unmask event |

## Verification
Three results come one register after the request edge: read data with `rsp_valid`, the unmask event, and the updated mask, address and data exports. The control register value also appears one edge after `ctl_we`. The bench drives each request half a cycle before the edge that samples it. It queues the expected read word right after that edge, and a monitor pops and compares the word at the next falling edge, when `rsp_valid` must be high. Write tasks sample `unmask_valid`, `unmask_idx` and the export buses at that same falling edge. A response that arrives with nothing queued counts as a miscompare.

// File: rtl/vtab_pkg.sv
package vtab_pkg;

    localparam int WORD_W  = 32;
    localparam int NFIELDS = 4;

    // Field slots inside one 16-byte entry; index i sits at byte offset 4*i.
    typedef enum logic [1:0] {
        FLD_ADDR_LO = 2'd0,
        FLD_ADDR_HI = 2'd1,
        FLD_DATA    = 2'd2,
        FLD_CTRL    = 2'd3
    } field_e;

    typedef logic [NFIELDS-1:0][WORD_W-1:0] entry_words_t;

    localparam logic [WORD_W-1:0] CTRL_RESET = 32'h0000_0001;

    // Decoded access: index range check, offset legality, touched fields.
    typedef struct packed {
        logic               in_range;
        logic               legal;
        logic [NFIELDS-1:0] fsel;
    } access_t;

endpackage

// File: rtl/vtab_decode.sv
module vtab_decode
    import vtab_pkg::*;
#(
    parameter int NUM_VEC = 8,
    parameter int ADDR_W  = 12,
    parameter int IDX_W   = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wide,
    output access_t           acc,
    output logic [IDX_W-1:0]  idx
);

    localparam int VW = ADDR_W - 4;

    logic [VW-1:0] vec_full;
    logic [3:0]    off;

    always_comb begin
        vec_full = addr[ADDR_W-1:4];
        off      = addr[3:0];
        idx      = vec_full[IDX_W-1:0];

        acc.in_range = ({{(32-VW){1'b0}}, vec_full} < 32'(NUM_VEC));

        case ({wide, off})
            5'b0_0000: acc.fsel = 4'b0001;
            5'b0_0100: acc.fsel = 4'b0010;
            5'b0_1000: acc.fsel = 4'b0100;
            5'b0_1100: acc.fsel = 4'b1000;
            5'b1_0000: acc.fsel = 4'b0011;
            5'b1_1000: acc.fsel = 4'b1100;
            default:   acc.fsel = 4'b0000;
        endcase
        acc.legal = |acc.fsel;
    end

endmodule

// File: rtl/vtab_entry.sv
module vtab_entry
    import vtab_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wide,
    input  logic [NFIELDS-1:0] fsel,
    input  logic [63:0]        wdata,
    output entry_words_t       words,
    output logic               unmask
);

    entry_words_t words_d, words_q;

    always_comb begin
        words_d = words_q;
        for (int i = 0; i < NFIELDS; i++) begin
            if (wr_en && fsel[i]) begin
                // In an 8-byte access the odd field rides the upper lane.
                words_d[i] = (wide && (i % 2 == 1)) ? wdata[63:32] : wdata[31:0];
            end
        end
        unmask = words_q[FLD_CTRL][0] && !words_d[FLD_CTRL][0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            words_q           <= '0;
            words_q[FLD_CTRL] <= CTRL_RESET;
        end else begin
            words_q <= words_d;
        end
    end

    assign words = words_q;

endmodule

// File: rtl/vec_table_regs.sv
module vec_table_regs
    import vtab_pkg::*;
#(
    parameter  int NUM_VEC = 8,
    parameter  int ADDR_W  = 12,
    localparam int IDX_W   = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req,
    input  logic                    we,
    input  logic                    wide,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [63:0]             wdata,
    output logic                    rsp_valid,
    output logic [63:0]             rsp_data,
    input  logic                    ctl_we,
    input  logic [15:0]             ctl_wdata,
    output logic [15:0]             ctl_rdata,
    output logic                    glb_enable,
    output logic                    fn_mask,
    output logic [NUM_VEC-1:0]      vec_masked,
    output logic [64*NUM_VEC-1:0]   vec_addr,
    output logic [32*NUM_VEC-1:0]   vec_data,
    output logic                    unmask_valid,
    output logic [IDX_W-1:0]        unmask_idx
);

    localparam logic [15:0] CTL_WMASK = 16'hC000;
    localparam logic [15:0] CTL_RESET = {2'b01, 3'b000, 11'(NUM_VEC - 1)};

    typedef struct packed {
        logic             rsp_v;
        logic [63:0]      rsp_d;
        logic             ev_v;
        logic [IDX_W-1:0] ev_idx;
        logic [15:0]      ctl;
    } state_t;

    state_t st_d, st_q;

    access_t          acc;
    logic [IDX_W-1:0] idx;

    vtab_decode #(
        .NUM_VEC (NUM_VEC),
        .ADDR_W  (ADDR_W),
        .IDX_W   (IDX_W)
    ) u_dec (
        .addr (addr),
        .wide (wide),
        .acc  (acc),
        .idx  (idx)
    );

    entry_words_t       ent   [NUM_VEC];
    logic [NUM_VEC-1:0] unm;
    logic               wr_ok;

    assign wr_ok = req && we && acc.in_range && acc.legal;

    for (genvar g = 0; g < NUM_VEC; g++) begin : g_vec
        logic sel;
        assign sel = wr_ok && (idx == IDX_W'(g));

        vtab_entry u_ent (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (sel),
            .wide   (wide),
            .fsel   (acc.fsel),
            .wdata  (wdata),
            .words  (ent[g]),
            .unmask (unm[g])
        );

        assign vec_masked[g]        = ent[g][FLD_CTRL][0];
        assign vec_addr[64*g +: 64] = {ent[g][FLD_ADDR_HI], ent[g][FLD_ADDR_LO]};
        assign vec_data[32*g +: 32] = ent[g][FLD_DATA];
    end

    entry_words_t rd_ent;
    logic [31:0]  lo_w, hi_w;

    always_comb begin
        rd_ent = '0;
        for (int i = 0; i < NUM_VEC; i++) begin
            if (idx == IDX_W'(i)) rd_ent = ent[i];
        end

        lo_w = '0;
        hi_w = '0;
        for (int f = 0; f < NFIELDS; f++) begin
            if (acc.fsel[f]) begin
                if (wide && (f % 2 == 1)) hi_w = hi_w | rd_ent[f];
                else                      lo_w = lo_w | rd_ent[f];
            end
        end

        st_d       = st_q;
        st_d.rsp_v = req && !we;
        st_d.ev_v  = 1'b0;

        if (req && !we) begin
            if (!acc.in_range)  st_d.rsp_d = wide ? '1 : 64'h0000_0000_FFFF_FFFF;
            else if (!acc.legal) st_d.rsp_d = '0;
            else                 st_d.rsp_d = {hi_w, lo_w};
        end

        for (int i = 0; i < NUM_VEC; i++) begin
            if (unm[i]) begin
                st_d.ev_v   = 1'b1;
                st_d.ev_idx = IDX_W'(i);
            end
        end

        if (ctl_we) begin
            st_d.ctl = (st_q.ctl & ~CTL_WMASK) | (ctl_wdata & CTL_WMASK);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.ctl <= CTL_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid    = st_q.rsp_v;
    assign rsp_data     = st_q.rsp_d;
    assign unmask_valid = st_q.ev_v;
    assign unmask_idx   = st_q.ev_idx;
    assign ctl_rdata    = st_q.ctl;
    assign glb_enable   = st_q.ctl[15];
    assign fn_mask      = st_q.ctl[14];

endmodule

// File: rtl/vtab_chk.sv
module vtab_chk #(
    parameter int NUM_VEC = 8,
    parameter int ADDR_W  = 12,
    parameter int IDX_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req,
    input logic               we,
    input logic               wide,
    input logic [ADDR_W-5:0]  vec_sel,
    input logic               rsp_valid,
    input logic [63:0]        rsp_data,
    input logic               ctl_we,
    input logic [15:0]        ctl_rdata,
    input logic [NUM_VEC-1:0] vec_masked,
    input logic               unmask_valid,
    input logic [IDX_W-1:0]   unmask_idx
);

    localparam int VW = ADDR_W - 4;

    logic               oor;
    logic [NUM_VEC-1:0] prev_masked;

    assign oor = ({{(32-VW){1'b0}}, vec_sel} >= 32'(NUM_VEC));

    always_ff @(posedge clk) begin
        if (!rst_n) prev_masked <= '1;
        else        prev_masked <= vec_masked;
    end

    // R9
    rsp_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we) |=> rsp_valid);

    // R9
    no_rsp_else_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req && !we) |=> !rsp_valid);

    // R8
    unmask_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unmask_valid |-> (prev_masked[unmask_idx] && !vec_masked[unmask_idx]));

    // R8
    unmask_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unmask_valid |-> $past(req && we));

    // R4
    oor_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && oor) |=> ($stable(vec_masked) && !unmask_valid));

    // R4
    oor_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && wide && oor) |=> (rsp_data == 64'hFFFF_FFFF_FFFF_FFFF));

    // R7
    ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_we |=> $stable(ctl_rdata));

endmodule

bind vec_table_regs vtab_chk #(
    .NUM_VEC (NUM_VEC),
    .ADDR_W  (ADDR_W),
    .IDX_W   (IDX_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req          (req),
    .we           (we),
    .wide         (wide),
    .vec_sel      (addr[ADDR_W-1:4]),
    .rsp_valid    (rsp_valid),
    .rsp_data     (rsp_data),
    .ctl_we       (ctl_we),
    .ctl_rdata    (ctl_rdata),
    .vec_masked   (vec_masked),
    .unmask_valid (unmask_valid),
    .unmask_idx   (unmask_idx)
);

// File: tb/tb_vec_table_regs.sv
module tb_vec_table_regs;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;
    localparam int AW = 12;
    localparam int IW = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req = 1'b0, we = 1'b0, wide = 1'b0;
    logic [AW-1:0]   addr = '0;
    logic [63:0]     wdata = '0;
    logic            rsp_valid;
    logic [63:0]     rsp_data;
    logic            ctl_we = 1'b0;
    logic [15:0]     ctl_wdata = '0;
    logic [15:0]     ctl_rdata;
    logic            glb_enable, fn_mask;
    logic [NV-1:0]   vec_masked;
    logic [64*NV-1:0] vec_addr;
    logic [32*NV-1:0] vec_data;
    logic            unmask_valid;
    logic [IW-1:0]   unmask_idx;

    vec_table_regs #(.NUM_VEC(NV), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .wide(wide),
        .addr(addr), .wdata(wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .glb_enable(glb_enable), .fn_mask(fn_mask), .vec_masked(vec_masked),
        .vec_addr(vec_addr), .vec_data(vec_data),
        .unmask_valid(unmask_valid), .unmask_idx(unmask_idx)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int          checks = 0;
    int          fails  = 0;
    bit          done   = 1'b0;
    logic [63:0] exp_q[$];
    string       tag_q[$];

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: request before the edge, queue the expected word after it.
    task automatic rd(logic [AW-1:0] a, logic w, logic [63:0] exp, string tag);
        @(negedge clk);
        req = 1'b1; we = 1'b0; wide = w; addr = a; wdata = '0;
        @(posedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic wr(logic [AW-1:0] a, logic w, logic [63:0] d,
                      logic exp_ev, logic [IW-1:0] exp_idx, string tag);
        @(negedge clk);
        req = 1'b1; we = 1'b1; wide = w; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
        chk({tag, " unmask_valid"}, 64'(unmask_valid), 64'(exp_ev));
        if (exp_ev) chk({tag, " unmask_idx"}, 64'(unmask_idx), 64'(exp_idx));
    endtask

    task automatic ctlw(logic [15:0] d);
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = d;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    // Monitor: pop and compare each response as it appears.
    always @(negedge clk) begin
        logic [63:0] e;
        string       t;
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R9: actual response %h expected none", rsp_data);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, rsp_data, e);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R9 watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 vec_masked", 64'(vec_masked), 64'hFF);
        chk("R1 ctl_rdata", 64'(ctl_rdata), 64'h4007);
        chk("R1 unmask idle", 64'(unmask_valid), 64'h0);
        rd(12'h03C, 1'b0, 64'h0000_0000_0000_0001, "R1 ctrl v3");
        rd(12'h030, 1'b1, 64'h0, "R1 addr v3");
        rd(12'h008, 1'b1, 64'h0000_0001_0000_0000, "R1 data/ctrl v0");

        // R2 4-byte fields
        wr(12'h020, 1'b0, 64'hFFFF_FFFF_A1A2_A3A4, 1'b0, 0, "R2 wr lo");
        wr(12'h024, 1'b0, 64'h0000_0000_B1B2_B3B4, 1'b0, 0, "R2 wr hi");
        wr(12'h028, 1'b0, 64'h0000_0000_C1C2_C3C4, 1'b0, 0, "R2 wr data");
        rd(12'h020, 1'b0, 64'h0000_0000_A1A2_A3A4, "R2 rd lo");
        rd(12'h024, 1'b0, 64'h0000_0000_B1B2_B3B4, "R2 rd hi");
        rd(12'h028, 1'b0, 64'h0000_0000_C1C2_C3C4, "R2 rd data");
        rd(12'h020, 1'b1, 64'hB1B2_B3B4_A1A2_A3A4, "R3 rd addr v2");
        rd(12'h028, 1'b1, 64'h0000_0001_C1C2_C3C4, "R3 rd ctrl/data v2");

        // R3 8-byte packing, R6 exports, R8 unmask through wide write
        wr(12'h050, 1'b1, 64'h1111_2222_3333_4444, 1'b0, 0, "R3 wr addr v5");
        rd(12'h050, 1'b0, 64'h0000_0000_3333_4444, "R3 lo v5");
        rd(12'h054, 1'b0, 64'h0000_0000_1111_2222, "R3 hi v5");
        rd(12'h050, 1'b1, 64'h1111_2222_3333_4444, "R3 wide v5");
        wr(12'h058, 1'b1, 64'h0000_0000_5555_6666, 1'b1, 3'd5, "R8 wide unmask v5");
        rd(12'h05C, 1'b0, 64'h0, "R3 ctrl v5");
        rd(12'h058, 1'b0, 64'h0000_0000_5555_6666, "R3 data v5");
        chk("R6 masked v5", 64'(vec_masked[5]), 64'h0);
        chk("R6 addr v5", vec_addr[5*64 +: 64], 64'h1111_2222_3333_4444);
        chk("R6 data v5", 64'(vec_data[5*32 +: 32]), 64'h5555_6666);

        // R8 transitions on vector 2
        wr(12'h02C, 1'b0, 64'h0, 1'b1, 3'd2, "R8 1to0");
        wr(12'h02C, 1'b0, 64'h0, 1'b0, 0, "R8 0to0");
        wr(12'h02C, 1'b0, 64'h1, 1'b0, 0, "R8 0to1");
        chk("R6 masked v2", 64'(vec_masked[2]), 64'h1);
        wr(12'h02C, 1'b0, 64'h1, 1'b0, 0, "R8 1to1");
        wr(12'h02C, 1'b0, 64'hFFFF_FFFE, 1'b1, 3'd2, "R8 1to0 upper");
        rd(12'h02C, 1'b0, 64'h0000_0000_FFFF_FFFE, "R8 ctrl readback v2");

        // R4 out of range
        rd(12'h080, 1'b0, 64'h0000_0000_FFFF_FFFF, "R4 narrow oor");
        rd(12'h088, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, "R4 wide oor");
        rd(12'h09A, 1'b0, 64'h0000_0000_FFFF_FFFF, "R4 oor bad offset");
        wr(12'h080, 1'b1, 64'hDEAD_BEEF_CAFE_F00D, 1'b0, 0, "R4 wr oor");
        wr(12'h08C, 1'b0, 64'h0, 1'b0, 0, "R4 wr oor ctrl");
        rd(12'h000, 1'b1, 64'h0, "R4 no alias v0");
        rd(12'h00C, 1'b0, 64'h1, "R4 no alias ctrl v0");
        chk("R4 masks", 64'(vec_masked), 64'hDB);

        // R5 illegal offsets
        rd(12'h022, 1'b0, 64'h0, "R5 narrow bad rd");
        rd(12'h024, 1'b1, 64'h0, "R5 wide bad rd");
        wr(12'h026, 1'b0, 64'h0, 1'b0, 0, "R5 narrow bad wr");
        rd(12'h024, 1'b0, 64'h0000_0000_B1B2_B3B4, "R5 hi v2 kept");
        wr(12'h054, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 0, "R5 wide bad wr");
        rd(12'h050, 1'b1, 64'h1111_2222_3333_4444, "R5 addr v5 kept");
        rd(12'h058, 1'b1, 64'h0000_0000_5555_6666, "R5 ctrl/data v5 kept");

        // R7 control register
        ctlw(16'hFFFF);
        chk("R7 all ones", 64'(ctl_rdata), 64'hC007);
        chk("R7 enable", 64'(glb_enable), 64'h1);
        ctlw(16'h8000);
        chk("R7 unmask fn", 64'(ctl_rdata), 64'h8007);
        chk("R7 fn_mask", 64'(fn_mask), 64'h0);
        ctlw(16'h0000);
        chk("R7 clear", 64'(ctl_rdata), 64'h0007);

        // R9 drain: every queued read must have been answered
        repeat (3) @(negedge clk);
        chk("R9 queue drained", 64'(exp_q.size()), 64'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule